// File: doc/BRIEF.md
# SPI Configuration Port Target Model

This block is a synthesizable stand-in for the command side of a device configuration port that is reached over SPI. A configuration sequencer under test drives it as it would drive the real port. The model takes 4-byte commands, keeps a live 32-bit status word, and answers status and identity reads on MISO. The status word shows busy, done, configuration-enabled, fail and a 3-bit error code. Erase and program-done start busy windows whose lengths are parameters. Program pages are counted for their length. Nothing is stored and no checksum is computed.

The SPI inputs are sampled by a fast system clock through a two-stage synchronizer. The model therefore works in SPI mode 0 for any SCK that is slow enough for that sampling: each SCK half period must be at least four system clocks. Two fault-injection inputs let a bench drive the sequencer's failure paths. One forces the fail bit. The other replaces the reported error code with a chosen value.

Top module: `cfgp_target`

## Requirements
- R1: After reset the status word is all zero, busy is clear, and MISO is 0.
- R2: A frame is CS_N low. Its first byte is the opcode and three operand bytes follow. Bytes are sampled on rising SCK, most significant bit first. After the fourth byte of opcode 3C, the next 32 SCK cycles of the same frame return a snapshot of the status word on MISO, most significant bit first. MISO changes on falling SCK. The status word holds busy at bit 12, fail at bit 13, done at bit 8, enabled at bit 9 and the error code at bits 25:23. Every other bit is 0.
- R3: After the fourth byte of opcode E0, the next 32 SCK cycles return the ID_WORD parameter, most significant bit first.
- R4: Opcode C6 sets the enabled bit and clears the error code to 0. Opcode 79 clears the enabled bit.
- R5: Opcode 0E clears done, forgets any programmed page, and holds busy for ERASE_CYCLES clocks.
- R6: For opcode 70, the byte count is judged when CS_N rises. Exactly 16 data bytes after the 4 opcode bytes records a programmed page. Any other count of 0 or more data bytes loads error code 6.
- R7: Opcode 5E clears done and holds busy for DONE_CYCLES clocks. Busy falls in the same clock in which done is set, and done is set only if a page has been recorded since the last erase. Busy and done are never both 1.
- R8: A first byte outside the set C6, 0E, 46, 70, 5E, 3C, 79, E0 loads error code 2 when the fourth byte completes. Opcode 46 changes no status bit.
- R9: While inj_fail is 1, status bit 13 reads 1. While inj_err_en is 1, bits 25:23 read inj_err_code. The stored error code reappears once inj_err_en returns to 0.
- R10: MISO is 0 while CS_N is high and during the four opcode bytes of every frame.
- R11: A frame that ends before its fourth byte completes changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | Active-low chip select that frames one command |
| mosi | input | 1 | Serial data from the sequencer |
| miso | output | 1 | Serial status or identity data to the sequencer |
| inj_fail | input | 1 | Forces the fail bit of the status word |
| inj_err_en | input | 1 | Replaces the reported error code with inj_err_code |
| inj_err_code | input | 3 | Error code shown while inj_err_en is 1 |

## Verification
The end of a busy window and the status snapshot taken by a read can fall in the same clock. The snapshot must then show one side of the transition and never a mixed word. The bench provokes this by starting a program-done and sweeping the idle gap before a status read across the cycle in which busy expires. Every snapshot must have exactly one of busy and done set, and the sweep must observe both sides. A checker also requires that done rises only in the clock in which busy falls.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    // Command opcodes (first byte of a frame)
    localparam logic [7:0] OP_ENABLE  = 8'hC6;
    localparam logic [7:0] OP_ERASE   = 8'h0E;
    localparam logic [7:0] OP_INITADR = 8'h46;
    localparam logic [7:0] OP_PROGPG  = 8'h70;
    localparam logic [7:0] OP_PDONE   = 8'h5E;
    localparam logic [7:0] OP_RDSTAT  = 8'h3C;
    localparam logic [7:0] OP_REFRESH = 8'h79;
    localparam logic [7:0] OP_RDID    = 8'hE0;

    // Status word bit positions
    localparam int ST_DONE   = 8;
    localparam int ST_ENAB   = 9;
    localparam int ST_BUSY   = 12;
    localparam int ST_FAIL   = 13;
    localparam int ST_ERR_LO = 23;
    localparam int ST_ERR_HI = 25;

    // Error codes
    localparam logic [2:0] ERR_NONE = 3'd0;
    localparam logic [2:0] ERR_CMD  = 3'd2;
    localparam logic [2:0] ERR_OVF  = 3'd6;

    localparam int WORD_W     = 32;
    localparam int HDR_BYTES  = 4;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], d[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= chain_d;
        end

        assign q[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/cfgp_shift.sv
module cfgp_shift #(
    parameter int TXW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sck_s,
    input  logic           cs_s,
    input  logic           mosi_s,
    input  logic           load,
    input  logic [TXW-1:0] load_word,
    output logic           byte_valid,
    output logic [7:0]     byte_data,
    output logic           cs_end,
    output logic           miso
);
    typedef struct packed {
        logic           sck_p;
        logic           cs_p;
        logic [2:0]     bitc;
        logic [7:0]     rx;
        logic           bv;
        logic           end_p;
        logic [TXW-1:0] tx;
        logic           skip;
    } shift_t;

    shift_t s_d, s_q;
    logic   rise, fall;

    always_comb begin
        rise        = sck_s & ~s_q.sck_p;
        fall        = ~sck_s & s_q.sck_p;
        s_d         = s_q;
        s_d.sck_p   = sck_s;
        s_d.cs_p    = cs_s;
        s_d.bv      = 1'b0;
        s_d.end_p   = cs_s & ~s_q.cs_p;
        if (cs_s) begin
            s_d.bitc = '0;
            s_d.tx   = '0;
            s_d.skip = 1'b0;
        end else begin
            if (rise) begin
                s_d.rx   = {s_q.rx[6:0], mosi_s};
                s_d.bitc = s_q.bitc + 3'd1;
                s_d.bv   = (s_q.bitc == 3'd7);
            end
            // Load keeps the first bit for the falling edge that follows the
            // last sampled bit; later falling edges advance the word.
            if (load) begin
                s_d.tx   = load_word;
                s_d.skip = 1'b1;
            end else if (fall) begin
                if (s_q.skip) s_d.skip = 1'b0;
                else          s_d.tx   = {s_q.tx[TXW-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.cs_p  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign byte_valid = s_q.bv;
    assign byte_data  = s_q.rx;
    assign cs_end     = s_q.end_p;
    assign miso       = s_q.tx[TXW-1];
endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
    import cfgp_pkg::*;
#(
    parameter int          PAGE_BYTES   = 16,
    parameter int          ERASE_CYCLES = 200,
    parameter int          DONE_CYCLES  = 150,
    parameter logic [31:0] ID_WORD      = 32'h0A5B_3C01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cs_end,
    input  logic              inj_fail,
    input  logic              inj_err_en,
    input  logic [2:0]        inj_err_code,
    output logic              load,
    output logic [WORD_W-1:0] load_word,
    output logic [WORD_W-1:0] status
);
    localparam int FRAME_BYTES = HDR_BYTES + PAGE_BYTES;
    localparam int IDXW        = $clog2(FRAME_BYTES + 2) + 1;
    localparam logic [IDXW-1:0] IDX_SAT = '1;
    localparam int CNT_MAX     = (ERASE_CYCLES > DONE_CYCLES) ? ERASE_CYCLES : DONE_CYCLES;
    localparam int CNTW        = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [7:0]      op;
        logic [IDXW-1:0] idx;
        logic            enab;
        logic            done;
        logic            page_ok;
        logic            done_pend;
        logic [2:0]      err;
        logic [CNTW-1:0] cnt;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        status                        = '0;
        status[ST_BUSY]               = (c_q.cnt != '0);
        status[ST_DONE]               = c_q.done;
        status[ST_ENAB]               = c_q.enab;
        status[ST_FAIL]               = inj_fail;
        status[ST_ERR_HI:ST_ERR_LO]   = inj_err_en ? inj_err_code : c_q.err;

        c_d       = c_q;
        load      = 1'b0;
        load_word = status;

        // Busy window countdown; done settles in the clock busy ends.
        if (c_q.cnt != '0) begin
            c_d.cnt = c_q.cnt - CNTW'(1);
            if (c_q.cnt == CNTW'(1) && c_q.done_pend) begin
                c_d.done      = c_q.page_ok;
                c_d.done_pend = 1'b0;
            end
        end

        if (byte_valid) begin
            if (c_q.idx != IDX_SAT) c_d.idx = c_q.idx + IDXW'(1);
            if (c_q.idx == '0) c_d.op = byte_data;
            if (c_q.idx == IDXW'(HDR_BYTES - 1)) begin
                case (c_q.op)
                    OP_ENABLE: begin
                        c_d.enab = 1'b1;
                        c_d.err  = ERR_NONE;
                    end
                    OP_ERASE: begin
                        c_d.done      = 1'b0;
                        c_d.page_ok   = 1'b0;
                        c_d.done_pend = 1'b0;
                        c_d.cnt       = CNTW'(ERASE_CYCLES);
                    end
                    OP_PDONE: begin
                        c_d.done      = 1'b0;
                        c_d.done_pend = 1'b1;
                        c_d.cnt       = CNTW'(DONE_CYCLES);
                    end
                    OP_RDSTAT: begin
                        load      = 1'b1;
                        load_word = status;
                    end
                    OP_RDID: begin
                        load      = 1'b1;
                        load_word = ID_WORD;
                    end
                    OP_REFRESH: c_d.enab = 1'b0;
                    OP_INITADR, OP_PROGPG: ;
                    default:    c_d.err = ERR_CMD;
                endcase
            end
        end

        if (cs_end) begin
            c_d.idx = '0;
            if (c_q.op == OP_PROGPG && c_q.idx >= IDXW'(HDR_BYTES)) begin
                if (c_q.idx == IDXW'(FRAME_BYTES)) c_d.page_ok = 1'b1;
                else                               c_d.err     = ERR_OVF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/cfgp_target.sv
module cfgp_target
    import cfgp_pkg::*;
#(
    parameter int          PAGE_BYTES   = 16,
    parameter int          ERASE_CYCLES = 200,
    parameter int          DONE_CYCLES  = 150,
    parameter int          SYNC_STAGES  = 2,
    parameter logic [31:0] ID_WORD      = 32'h0A5B_3C01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       miso,
    input  logic       inj_fail,
    input  logic       inj_err_en,
    input  logic [2:0] inj_err_code
);
    logic [2:0]        pins_s;
    logic              sck_s, cs_s, mosi_s;
    logic              byte_valid_w, cs_end_w, load_w;
    logic [7:0]        byte_data_w;
    logic [WORD_W-1:0] load_word_w, status_w;

    cfgp_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, mosi}),
        .q     (pins_s)
    );

    assign cs_s   = pins_s[2];
    assign sck_s  = pins_s[1];
    assign mosi_s = pins_s[0];

    cfgp_shift #(.TXW(WORD_W)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (sck_s),
        .cs_s       (cs_s),
        .mosi_s     (mosi_s),
        .load       (load_w),
        .load_word  (load_word_w),
        .byte_valid (byte_valid_w),
        .byte_data  (byte_data_w),
        .cs_end     (cs_end_w),
        .miso       (miso)
    );

    cfgp_ctrl #(
        .PAGE_BYTES   (PAGE_BYTES),
        .ERASE_CYCLES (ERASE_CYCLES),
        .DONE_CYCLES  (DONE_CYCLES),
        .ID_WORD      (ID_WORD)
    ) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid   (byte_valid_w),
        .byte_data    (byte_data_w),
        .cs_end       (cs_end_w),
        .inj_fail     (inj_fail),
        .inj_err_en   (inj_err_en),
        .inj_err_code (inj_err_code),
        .load         (load_w),
        .load_word    (load_word_w),
        .status       (status_w)
    );
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
    import cfgp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] status,
    input logic              byte_valid,
    input logic              cs_end,
    input logic              cs_s,
    input logic              load,
    input logic              miso,
    input logic              inj_err_en
);
    // R7: busy and done are exclusive
    a_r7_busy_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_BUSY] |-> !status[ST_DONE]);

    // R7: done rises only as busy ends
    a_r7_done_at_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_DONE]) |-> $fell(status[ST_BUSY]));

    // R10: MISO quiet while deselected
    a_r10_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !miso);

    // R2: a reply is only armed inside a frame
    a_r2_load_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !cs_s);

    // R8: the stored error code moves only after a byte or frame end
    a_r8_err_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(status[ST_ERR_HI:ST_ERR_LO]) && !inj_err_en && $past(!inj_err_en))
        |-> $past(byte_valid || cs_end));
endmodule

bind cfgp_target cfgp_checker i_cfgp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .status     (status_w),
    .byte_valid (byte_valid_w),
    .cs_end     (cs_end_w),
    .cs_s       (cs_s),
    .load       (load_w),
    .miso       (miso),
    .inj_err_en (inj_err_en)
);

// File: tb/test_cfgp_target.sv
`timescale 1ns/1ps
module test_cfgp_target;
    localparam int          ERASE_C = 1500;
    localparam int          DONE_C  = 1200;
    localparam logic [31:0] IDW     = 32'hC0DE_5A17;

    logic clk = 1'b0;
    logic rst_n, sck, cs_n, mosi, miso;
    logic inj_fail, inj_err_en;
    logic [2:0] inj_err_code;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    logic [7:0] hdr_or;

    // bench model
    bit       m_enab, m_done, m_page;
    bit [2:0] m_err;

    always #5 clk = ~clk;

    cfgp_target #(
        .ERASE_CYCLES (ERASE_C),
        .DONE_CYCLES  (DONE_C),
        .ID_WORD      (IDW)
    ) i_cfgp_target (
        .clk (clk), .rst_n (rst_n), .sck (sck), .cs_n (cs_n), .mosi (mosi),
        .miso (miso), .inj_fail (inj_fail), .inj_err_en (inj_err_en),
        .inj_err_code (inj_err_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        w[8] = m_done; w[9] = m_enab; w[25:23] = m_err;
        return w;
    endfunction

    function automatic bit is_known(input logic [7:0] b);
        return b inside {8'hC6, 8'h0E, 8'h46, 8'h70, 8'h5E, 8'h3C, 8'h79, 8'hE0};
    endfunction

    task automatic spi_byte(input logic [7:0] tb, output logic [7:0] rb);
        for (int i = 7; i >= 0; i--) begin
            mosi = tb[i];
            repeat (6) @(negedge clk);
            rb[i] = miso;
            sck = 1'b1;
            repeat (6) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    // opcode, operand bytes cut at nhdr (<4 gives a short frame), ndata extra bytes
    task automatic frame(input logic [7:0] op, input int nhdr, input int ndata,
                         output logic [31:0] rd);
        logic [7:0] r;
        rd = '0;
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nhdr; i++) begin
            spi_byte((i == 0) ? op : ((i == 3 && op == 8'h70) ? 8'h01 : 8'h00), r);
            hdr_or |= r;
        end
        for (int i = 0; i < ndata; i++) begin
            spi_byte(8'($urandom), r);
            rd = {rd[23:0], r};
        end
        repeat (6) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op, input int ndata);
        logic [31:0] x;
        frame(op, 4, ndata, x);
    endtask

    task automatic rd_status(output logic [31:0] s);
        frame(8'h3C, 4, 4, s);
    endtask

    task automatic wait_idle(input string tag, output int polls, output logic [31:0] s);
        polls = 0;
        do begin
            rd_status(s);
            polls++;
        end while (s[12] && polls < 8);
        chk(tag, {31'd0, s[12]}, 32'd0);
    endtask

    initial begin : wdog
        repeat (199000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] s;
        int          polls;
        bit          saw_busy, saw_done;
        void'($urandom(32'd1234));
        rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0;
        inj_fail = 1'b0; inj_err_en = 1'b0; inj_err_code = 3'd0;
        hdr_or = 8'h00;
        m_enab = 0; m_done = 0; m_page = 0; m_err = 0;
        repeat (10) @(negedge clk);
        chk("R1 miso in reset", {31'd0, miso}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        rd_status(s);
        chk("R1 status after reset", s, 32'h0);

        frame(8'hE0, 4, 4, s);
        chk("R3 read id", s, IDW);

        cmd(8'hC6, 0); m_enab = 1; m_err = 0;
        rd_status(s); chk("R4 enable sets bit 9", s, model_word());
        cmd(8'h79, 0); m_enab = 0;
        rd_status(s); chk("R4 refresh clears bit 9", s, model_word());

        cmd(8'hA7, 0); m_err = 3'd2;
        rd_status(s); chk("R8 unknown opcode error 2", s, model_word());
        cmd(8'h46, 0);
        rd_status(s); chk("R8 init address no change", s, model_word());
        cmd(8'hC6, 0); m_enab = 1; m_err = 0;
        rd_status(s); chk("R4 enable clears error", s, model_word());

        // erase: busy right after, then idle with done clear
        cmd(8'h0E, 0); m_done = 0; m_page = 0;
        rd_status(s); chk("R5 erase busy", s, model_word() | 32'h1000);
        wait_idle("R5 erase ends", polls, s);
        chk("R5 erase idle word", s, model_word());

        // program-done with no page: done stays 0
        cmd(8'h5E, 0);
        rd_status(s); chk("R7 progdone busy", s, model_word() | 32'h1000);
        wait_idle("R7 progdone ends", polls, s);
        chk("R7 no page no done", s, model_word());

        // one good page then program-done
        cmd(8'h70, 16); m_page = 1;
        rd_status(s); chk("R6 good page no error", s, model_word());
        cmd(8'h5E, 0);
        wait_idle("R7 progdone ends", polls, s);
        m_done = 1;
        chk("R7 done after page", s, model_word());

        // short frames do nothing
        begin
            logic [31:0] x;
            frame(8'h0E, 2, 0, x);
            frame(8'hA7, 3, 0, x);
        end
        rd_status(s); chk("R11 short frames ignored", s, model_word());

        // wrong page lengths
        cmd(8'h70, 15); m_err = 3'd6;
        rd_status(s); chk("R6 short page error 6", s, model_word());
        cmd(8'hC6, 0); m_err = 0;
        cmd(8'h70, 17); m_err = 3'd6;
        rd_status(s); chk("R6 long page error 6", s, model_word());

        // fault injection
        inj_fail = 1'b1;
        rd_status(s); chk("R9 injected fail", s, model_word() | 32'h2000);
        inj_fail = 1'b0;
        inj_err_en = 1'b1; inj_err_code = 3'd5;
        rd_status(s); chk("R9 injected code", s, (model_word() & ~32'h0380_0000) | (32'd5 << 23));
        inj_err_en = 1'b0;
        rd_status(s); chk("R9 stored code returns", s, model_word());
        cmd(8'hC6, 0); m_err = 0;

        // busy expiry against the status snapshot
        saw_busy = 0; saw_done = 0;
        for (int g = 700; g <= 900; g += 10) begin
            cmd(8'h5E, 0);
            repeat (g) @(negedge clk);
            rd_status(s);
            chk("R7 busy xor done", {31'd0, s[12] ^ s[8]}, 32'd1);
            if (s[12]) saw_busy = 1;
            if (s[8])  saw_done = 1;
            wait_idle("R7 sweep idle", polls, s);
        end
        chk("R7 sweep saw both sides", {30'd0, saw_busy, saw_done}, 32'd3);
        m_done = 1;

        // random command mix
        for (int n = 0; n < 40; n++) begin
            int sel;
            sel = int'($urandom_range(0, 6));
            case (sel)
                0: begin cmd(8'hC6, 0); m_enab = 1; m_err = 0; end
                1: begin cmd(8'h79, 0); m_enab = 0; end
                2: begin
                    logic [7:0] b;
                    do b = 8'($urandom); while (is_known(b));
                    cmd(b, 0); m_err = 3'd2;
                end
                3: begin
                    int len;
                    len = int'($urandom_range(14, 18));
                    cmd(8'h70, len);
                    if (len == 16) m_page = 1; else m_err = 3'd6;
                end
                4: cmd(8'h46, 0);
                5: begin frame(8'hE0, 4, 4, s); chk("R3 random read id", s, IDW); end
                default: ;
            endcase
            rd_status(s);
            chk("R2 random status word", s, model_word());
        end
        chk("R10 miso quiet in opcode bytes", {24'd0, hdr_or}, 32'd0);
        @(negedge clk);
        chk("R10 miso idle", {31'd0, miso}, 32'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule